// File: doc/BRIEF.md
# Programmable Card Clock Divider with Commit Handshake

This block derives the clock driven to one or more card slots from the reference clock of the controller. Host software writes a staged divide value and a staged set of per-slot gate bits into holding registers, and the running clock does not change at that point. The settings reach the running clock only when software writes a command word that carries both a start flag and a clock-update-only flag. The block then applies the staged pair at a safe point of the output waveform and drops the start flag. Software polls this flag to learn that the change is complete.

A divide value N of 1 or more gives a card clock period of 2N reference cycles with an even duty cycle. A value of 0 passes the reference clock straight through. A combinational helper turns a requested target frequency into the divide value that software should stage. The helper rounds up so that the card never runs faster than requested, and it clamps the result to the largest value that can be encoded.

Top module: `card_clk_divider`

## Requirements
- R1: After synchronous reset, the start flag reads 0, every card clock output is low, the active divide value is 0 and all gate bits are 0.
- R2: For a target frequency T below the reference frequency F, the helper output is ceil(F / (2T)). For example, F=100000 and T=30000 give 2, and T=400 gives 125.
- R3: When T is equal to or greater than F, the helper output is 0.
- R4: The helper output saturates at 2^DIV_W-1, which is 255 by default. A target of 0 also yields that maximum.
- R5: With an active divide value N>0, each enabled card clock is high for exactly N reference cycles and then low for exactly N.
- R6: With an active divide value of 0, each enabled card clock follows the reference clock level.
- R7: Card clock output i is gated by active gate bit i. While that bit is 0, the output stays low.
- R8: Writing the divide register (wr_addr 0, value in bits DIV_W-1:0) or the gate register (wr_addr 1, bits NPORT-1:0) has no effect on the outputs until a commit command is accepted.
- R9: A command word (wr_addr 2) is accepted only when bit 31 (start) and bit 13 (update-clock-only) are both 1 and no command is pending. A word with start=1 and update=0 leaves the start flag at 0 and the clock unchanged.
- R10: After an accepted command, the start flag reads 1. It returns to 0 in the cycle the staged settings take effect, which is no later than 2N+1 cycles after acceptance, where N is the divide value active before the command (1 cycle when N=0).
- R11: New settings take effect only while the divided output is in its low phase and that phase has run its full length, so the output never produces a high pulse shorter than N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divide, 1 gate, 2 command |
| wr_data | input | 32 | Write data |
| start_flag | output | 1 | Readback of the command start bit; 1 while a commit is pending |
| target_freq | input | FREQ_W | Requested card frequency for the helper, in the same unit as REF_FREQ |
| div_hint | output | DIV_W | Divide value computed by the helper |
| card_clk | output | NPORT | Gated card clock for each slot |

## Verification
If the active settings are corrupted, the card clock shows it within one output period. A wrong divide count shows up as a high or low run of the wrong length. A wrong gate bit shows up as a slot that toggles when it should not, or one that stays silent. If the handshake is broken, the start flag stays stuck at 1 past the 2N+1 cycle bound, or it clears without the waveform changing. If the commit point is wrong, it shows up as a shortened high pulse in the cycles around the flag clearing. Each commit scenario therefore watches slot 0 across the whole window from acceptance to the new steady state.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    localparam int WORD_W         = 32;
    localparam int CMD_START_BIT  = 31;
    localparam int CMD_UPDATE_BIT = 13;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_GATE = 2'd1,
        SEL_CMD  = 2'd2
    } reg_sel_e;

    // Divide value for a requested frequency: ceil(ref / (2*tgt)), clamped.
    function automatic logic [63:0] calc_div(input logic [63:0] ref_f,
                                             input logic [63:0] tgt_f,
                                             input logic [63:0] max_d);
        logic [63:0] twice;
        logic [63:0] quo;
        if (tgt_f >= ref_f)
            return 64'd0;
        if (tgt_f == 64'd0)
            return max_d;
        twice = tgt_f << 1;
        quo   = ref_f / twice;
        if ((ref_f % twice) != 64'd0)
            quo = quo + 64'd1;
        if (quo > max_d)
            quo = max_d;
        return quo;
    endfunction

endpackage

// File: rtl/ccd_regs.sv
module ccd_regs
    import ccd_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                commit,
    output logic [DIV_W-1:0]    stage_div,
    output logic [NPORT-1:0]    stage_gate,
    output logic                pending
);

    reg_sel_e sel;
    logic     cmd_ok;

    always_comb begin
        sel    = reg_sel_e'(wr_addr);
        cmd_ok = wr_en && (sel == SEL_CMD) && !pending
                 && wr_data[CMD_START_BIT] && wr_data[CMD_UPDATE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_div  <= '0;
            stage_gate <= '0;
        end else if (wr_en) begin
            if (sel == SEL_DIV)
                stage_div <= wr_data[DIV_W-1:0];
            if (sel == SEL_GATE)
                stage_gate <= wr_data[NPORT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (commit)
            pending <= 1'b0;
        else if (cmd_ok)
            pending <= 1'b1;
    end

endmodule

// File: rtl/ccd_divgen.sv
module ccd_divgen #(
    parameter int NPORT = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pending,
    input  logic [DIV_W-1:0] stage_div,
    input  logic [NPORT-1:0] stage_gate,
    output logic [DIV_W-1:0] act_div,
    output logic [NPORT-1:0] act_gate,
    output logic             phase,
    output logic [DIV_W-1:0] div_cnt,
    output logic             commit
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic running;
    logic half_end;
    logic safe_pt;

    always_comb begin
        running  = (act_div != '0);
        half_end = running && (div_cnt == act_div - ONE);
        // Safe point: bypass, or the last cycle of a complete low half.
        safe_pt  = !running || (!phase && half_end);
        commit   = pending && safe_pt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_div  <= '0;
            act_gate <= '0;
            div_cnt  <= '0;
            phase    <= 1'b0;
        end else if (commit) begin
            act_div  <= stage_div;
            act_gate <= stage_gate;
            div_cnt  <= '0;
            phase    <= 1'b0;
        end else if (running) begin
            if (half_end) begin
                div_cnt <= '0;
                phase   <= ~phase;
            end else begin
                div_cnt <= div_cnt + ONE;
            end
        end
    end

endmodule

// File: rtl/ccd_gate.sv
module ccd_gate #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             phase,
    input  logic             bypass,
    input  logic [NPORT-1:0] act_gate,
    output logic [NPORT-1:0] card_clk
);

    logic src;

    always_comb src = bypass ? clk : phase;

    for (genvar i = 0; i < NPORT; i++) begin : g_slot
        assign card_clk[i] = act_gate[i] & src;
    end

endmodule

// File: rtl/ccd_freq_calc.sv
module ccd_freq_calc
    import ccd_pkg::*;
#(
    parameter int          FREQ_W   = 32,
    parameter int          DIV_W    = 8,
    parameter int unsigned REF_FREQ = 100000
) (
    input  logic [FREQ_W-1:0] target_freq,
    output logic [DIV_W-1:0]  div_hint
);

    localparam logic [63:0] MAX_DIV = (64'd1 << DIV_W) - 64'd1;

    logic [63:0] wide;

    always_comb begin
        wide     = calc_div(64'(REF_FREQ), 64'(target_freq), MAX_DIV);
        div_hint = wide[DIV_W-1:0];
    end

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import ccd_pkg::*;
#(
    parameter int          NPORT    = 4,
    parameter int          DIV_W    = 8,
    parameter int          FREQ_W   = 32,
    parameter int unsigned REF_FREQ = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              start_flag,
    input  logic [FREQ_W-1:0] target_freq,
    output logic [DIV_W-1:0]  div_hint,
    output logic [NPORT-1:0]  card_clk
);

    logic [DIV_W-1:0] stage_div;
    logic [NPORT-1:0] stage_gate;
    logic             pending;
    logic             commit;
    logic [DIV_W-1:0] act_div;
    logic [NPORT-1:0] act_gate;
    logic             phase;
    logic [DIV_W-1:0] div_cnt;
    logic             bypass;

    ccd_regs #(.NPORT(NPORT), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .stage_div  (stage_div),
        .stage_gate (stage_gate),
        .pending    (pending)
    );

    ccd_divgen #(.NPORT(NPORT), .DIV_W(DIV_W)) u_divgen (
        .clk        (clk),
        .rst        (rst),
        .pending    (pending),
        .stage_div  (stage_div),
        .stage_gate (stage_gate),
        .act_div    (act_div),
        .act_gate   (act_gate),
        .phase      (phase),
        .div_cnt    (div_cnt),
        .commit     (commit)
    );

    always_comb bypass = (act_div == '0);

    ccd_gate #(.NPORT(NPORT)) u_gate (
        .clk      (clk),
        .phase    (phase),
        .bypass   (bypass),
        .act_gate (act_gate),
        .card_clk (card_clk)
    );

    ccd_freq_calc #(.FREQ_W(FREQ_W), .DIV_W(DIV_W), .REF_FREQ(REF_FREQ)) u_calc (
        .target_freq (target_freq),
        .div_hint    (div_hint)
    );

    always_comb start_flag = pending;

endmodule

// File: rtl/ccd_checker.sv
module ccd_checker
    import ccd_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DIV_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              start_flag,
    input logic [DIV_W-1:0]  act_div,
    input logic [NPORT-1:0]  act_gate,
    input logic              phase,
    input logic [DIV_W-1:0]  div_cnt,
    input logic [NPORT-1:0]  card_clk
);

    localparam int LIMIT = 2 * ((1 << DIV_W) - 1) + 1;

    logic [DIV_W+2:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !start_flag)
            wait_cnt <= '0;
        else
            wait_cnt <= wait_cnt + 1'b1;
    end

    // R10: start flag never outlives the worst-case commit window
    a_r10_start_bounded: assert property (@(posedge clk) disable iff (rst)
        start_flag |-> (int'(wait_cnt) <= LIMIT));

    // R11: active settings change only after a low phase
    a_r11_commit_low: assert property (@(posedge clk) disable iff (rst)
        ((act_div != $past(act_div)) || (act_gate != $past(act_gate)))
        |-> ($past(phase) == 1'b0));

    // R5: half-period counter stays inside the divide value
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (act_div != '0) |-> (div_cnt < act_div));

    // R6: bypass mode keeps the divided phase parked low
    a_r6_bypass_phase: assert property (@(posedge clk) disable iff (rst)
        (act_div == '0) |-> (phase == 1'b0));

    // R7: a disabled slot never drives high
    a_r7_gate_low: assert property (@(posedge clk) disable iff (rst)
        (card_clk & ~act_gate) == '0);

    // R9: a start without update-only leaves the flag clear
    a_r9_need_update: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 2'd2) && wr_data[CMD_START_BIT]
         && !wr_data[CMD_UPDATE_BIT] && !start_flag) |=> !start_flag);

endmodule

bind card_clk_divider ccd_checker #(.NPORT(NPORT), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .start_flag (start_flag),
    .act_div    (act_div),
    .act_gate   (act_gate),
    .phase      (phase),
    .div_cnt    (div_cnt),
    .card_clk   (card_clk)
);

// File: tb/tb_card_clk_divider.sv
module tb_card_clk_divider;

    localparam int NPORT = 4;
    localparam int DIV_W = 8;
    localparam int FREQ_W = 32;
    localparam int WD_CYCLES = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              start_flag;
    logic [FREQ_W-1:0] target_freq = '0;
    logic [DIV_W-1:0]  div_hint;
    logic [NPORT-1:0]  card_clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int cur_div  = 0;
    logic [NPORT-1:0] cur_gate = '0;

    always #2 clk = ~clk;

    card_clk_divider dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .start_flag  (start_flag),
        .target_freq (target_freq),
        .div_hint    (div_hint),
        .card_clk    (card_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Measures one full high run and one full low run of slot p.
    task automatic measure(input int p, input int n, input string req);
        int guard = 0;
        int hi = 0;
        int lo = 0;
        while (card_clk[p] !== 1'b0 && guard < 1200) begin @(negedge clk); guard++; end
        while (card_clk[p] !== 1'b1 && guard < 1200) begin @(negedge clk); guard++; end
        while (card_clk[p] === 1'b1 && hi < 600) begin @(negedge clk); hi++; end
        while (card_clk[p] === 1'b0 && lo < 600) begin @(negedge clk); lo++; end
        check(hi == n, {req, " high run"}, hi, n);
        check(lo == n, {req, " low run"}, lo, n);
    endtask

    // Stages and commits; checks flag timing and absence of short pulses.
    task automatic commit(input int n, input logic [NPORT-1:0] g);
        int polls = 0;
        int run = 0;
        int min_hi = 9999;
        bit seen_low = 1'b0;
        int bound;
        bound = (cur_div == 0) ? 1 : 2 * cur_div + 1;
        reg_write(2'd0, 32'(n));
        reg_write(2'd1, 32'(g));
        reg_write(2'd2, (32'd1 << 31) | (32'd1 << 13));
        check(start_flag == 1'b1, "R10 flag set after command", int'(start_flag), 1);
        for (int c = 0; c < 2 * cur_div + 2 * n + 8; c++) begin
            if (start_flag) polls++;
            if (card_clk[0] === 1'b1) run++;
            else begin
                if (seen_low && run > 0 && run < min_hi) min_hi = run;
                run = 0;
                seen_low = 1'b1;
            end
            @(negedge clk);
        end
        check(start_flag == 1'b0, "R10 flag cleared", int'(start_flag), 0);
        check(polls <= bound, "R10 commit latency", polls, bound);
        if (cur_div > 0 && n > 0 && cur_gate[0] && g[0]) begin
            int lim;
            lim = (cur_div < n) ? cur_div : n;
            check(min_hi >= lim, "R11 no short high pulse", min_hi, lim);
        end
        cur_div  = n;
        cur_gate = g;
    endtask

    task automatic t_reset;
        check(start_flag == 1'b0, "R1 start flag", int'(start_flag), 0);
        check(card_clk == '0, "R1 card clocks low", int'(card_clk), 0);
        @(posedge clk); #1;
        check(card_clk == '0, "R1 low in high ref phase", int'(card_clk), 0);
        @(negedge clk);
    endtask

    task automatic t_helper;
        target_freq = 32'd400;    #1; check(div_hint == 8'd125, "R2 exact 400", int'(div_hint), 125);
        target_freq = 32'd30000;  #1; check(div_hint == 8'd2,   "R2 round up 30000", int'(div_hint), 2);
        target_freq = 32'd25000;  #1; check(div_hint == 8'd2,   "R2 exact 25000", int'(div_hint), 2);
        target_freq = 32'd100000; #1; check(div_hint == 8'd0,   "R3 equal ref", int'(div_hint), 0);
        target_freq = 32'd200000; #1; check(div_hint == 8'd0,   "R3 above ref", int'(div_hint), 0);
        target_freq = 32'd150;    #1; check(div_hint == 8'd255, "R4 saturate", int'(div_hint), 255);
        target_freq = 32'd0;      #1; check(div_hint == 8'd255, "R4 zero target", int'(div_hint), 255);
    endtask

    task automatic t_staging_ignored;
        reg_write(2'd0, 32'd7);
        reg_write(2'd1, 32'd0);
        measure(0, 3, "R8 staged values not applied");
        check(start_flag == 1'b0, "R8 flag untouched", int'(start_flag), 0);
    endtask

    task automatic t_start_only;
        reg_write(2'd2, 32'd1 << 31);
        check(start_flag == 1'b0, "R9 start without update", int'(start_flag), 0);
        measure(0, 3, "R9 clock unchanged");
    endtask

    task automatic t_gating;
        commit(2, 4'b0101);
        measure(0, 2, "R7 enabled slot 0");
        measure(2, 2, "R7 enabled slot 2");
        for (int c = 0; c < 12; c++) begin
            check(card_clk[1] == 1'b0 && card_clk[3] == 1'b0, "R7 disabled slots low",
                  int'({card_clk[3], card_clk[1]}), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_bypass;
        commit(0, 4'b0011);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            check(card_clk == 4'b0011, "R6 follows ref high", int'(card_clk), 3);
            @(negedge clk); #1;
            check(card_clk == 4'b0000, "R6 follows ref low", int'(card_clk), 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_helper();
        commit(3, 4'b1111);
        measure(0, 3, "R5 divide by 3");
        t_staging_ignored();
        t_start_only();
        commit(5, 4'b1111);
        measure(1, 5, "R5 divide by 5");
        t_gating();
        t_bypass();
        commit(1, 4'b1111);
        measure(3, 1, "R5 divide by 1");
        commit(255, 4'b0001);
        measure(0, 255, "R5 divide by 255");
        commit(4, 4'b0001);
        measure(0, 4, "R5 divide by 4 after maximum");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule